// File: doc/BRIEF.md
# Segment Address Translator

This block relocates a logical offset into a physical address through a small on-chip table of segment descriptors. A request names a segment with a selector and supplies an offset. The chosen descriptor gives a base address, a byte limit and a valid bit. The base and the offset are added to form the physical address. In the same cycle, the offset is compared against the limit. Every descriptor is held in registers inside the block, so a translation never needs a memory access.

An offset beyond the limit makes the block report an access fault. A selector that picks an invalid descriptor also makes it report a fault. In either case the access is suppressed: the grant flag stays low and the address bus reads zero. The response appears one clock after the request.

The descriptor table is loaded through a write port. That port only has effect while the protected-mode input is high. A write attempted at any other time leaves the table exactly as it was.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset every descriptor is invalid, and rsp_valid_o, rsp_ok_o, rsp_fault_o and rsp_paddr_o are all zero.
- R2: A request accepted on a clock edge (req_valid_i high) is answered on the next edge with rsp_valid_o high. On a grant, rsp_paddr_o holds (base + offset) modulo 2^32, where the offset is zero-extended.
- R3: An offset equal to the limit is granted, and one strictly greater faults. An offset with any bit at or above the limit width always faults.
- R4: A request whose selected descriptor has its valid bit clear faults, whatever the offset.
- R5: A faulting response has rsp_ok_o low and rsp_paddr_o zero. rsp_ok_o and rsp_fault_o are never high together.
- R6: A descriptor write with prot_mode_i low is ignored. Later requests see the previous base, limit and valid bit.
- R7: A write with prot_mode_i high to entry cfg_idx_i changes that entry from the following edge on. A request in the same cycle as the write uses the old contents.
- R8: In a cycle after an edge with req_valid_i low, rsp_valid_o, rsp_ok_o, rsp_fault_o and rsp_paddr_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prot_mode_i | input | 1 | Protected mode; descriptor writes count only while high |
| cfg_we_i | input | 1 | Descriptor write strobe |
| cfg_idx_i | input | 3 | Descriptor index to write |
| cfg_base_i | input | 32 | New base address |
| cfg_limit_i | input | 20 | New byte limit (highest allowed offset) |
| cfg_valid_i | input | 1 | New valid bit |
| req_valid_i | input | 1 | Translate request strobe |
| req_sel_i | input | 3 | Segment selector |
| req_ofs_i | input | 24 | Logical offset |
| rsp_valid_o | output | 1 | Response present, one cycle after the request |
| rsp_ok_o | output | 1 | Access granted |
| rsp_fault_o | output | 1 | Access fault (over limit or invalid descriptor) |
| rsp_paddr_o | output | 32 | Physical address; zero unless granted |

## Verification
The bench sweeps every selector against the offsets that sit around its limit: zero, limit-1, limit, limit+1, the largest limit-width offset and an offset with high bits set. A comparator that used greater-or-equal would then fault exactly at the limit, and one truncated to the limit width would grant the high-bit offsets. A base near the top of the address space catches an adder that saturates or widens rather than wrapping. An entry with a zero limit and an entry left invalid show whether the valid bit is really part of the fault decision. The bench also writes outside protected mode and then reads back through translations, to expose a table that ignores the gate. A write and a request in the same cycle show whether the read path bypasses the register that is still being written.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int unsigned SEG_NUM_DEF  = 8;
  localparam int unsigned SEG_BASE_DEF = 32;
  localparam int unsigned SEG_LIM_DEF  = 20;
  localparam int unsigned SEG_OFS_DEF  = 24;

  typedef enum logic [1:0] {
    RSP_IDLE  = 2'b00,
    RSP_GRANT = 2'b01,
    RSP_FAULT = 2'b10
  } rsp_kind_e;
endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table #(
  parameter int unsigned NUM_SEG = seg_xlate_pkg::SEG_NUM_DEF,
  parameter int unsigned BASE_W  = seg_xlate_pkg::SEG_BASE_DEF,
  parameter int unsigned LIM_W   = seg_xlate_pkg::SEG_LIM_DEF,
  localparam int unsigned SEL_W  = $clog2(NUM_SEG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prot_i,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_idx_i,
  input  logic [BASE_W-1:0] wr_base_i,
  input  logic [LIM_W-1:0]  wr_limit_i,
  input  logic              wr_valid_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  output logic [BASE_W-1:0] rd_base_o,
  output logic [LIM_W-1:0]  rd_limit_o,
  output logic              rd_valid_o
);
  logic [BASE_W-1:0] base_a  [NUM_SEG];
  logic [LIM_W-1:0]  limit_a [NUM_SEG];
  logic              valid_a [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_ent
    logic              hit;
    logic [BASE_W-1:0] base_q;
    logic [LIM_W-1:0]  limit_q;
    logic              valid_q;

    assign hit = wr_en_i && prot_i && (wr_idx_i == SEL_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q  <= '0;
        limit_q <= '0;
        valid_q <= 1'b0;
      end else if (hit) begin
        base_q  <= wr_base_i;
        limit_q <= wr_limit_i;
        valid_q <= wr_valid_i;
      end
    end

    assign base_a[g]  = base_q;
    assign limit_a[g] = limit_q;
    assign valid_a[g] = valid_q;
  end

  assign rd_base_o  = base_a[rd_sel_i];
  assign rd_limit_o = limit_a[rd_sel_i];
  assign rd_valid_o = valid_a[rd_sel_i];
endmodule

// File: rtl/seg_bound_check.sv
module seg_bound_check #(
  parameter int unsigned LIM_W = seg_xlate_pkg::SEG_LIM_DEF,
  parameter int unsigned OFS_W = seg_xlate_pkg::SEG_OFS_DEF,
  localparam int unsigned CMP_W = (OFS_W > LIM_W) ? OFS_W : LIM_W
) (
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [LIM_W-1:0] limit_i,
  input  logic             desc_valid_i,
  output logic             fault_o
);
  logic [CMP_W-1:0] ofs_x, lim_x;
  assign ofs_x   = CMP_W'(ofs_i);
  assign lim_x   = CMP_W'(limit_i);
  // limit is inclusive: only strictly greater offsets fault
  assign fault_o = !desc_valid_i || (ofs_x > lim_x);
endmodule

// File: rtl/seg_reloc_add.sv
module seg_reloc_add #(
  parameter int unsigned BASE_W = seg_xlate_pkg::SEG_BASE_DEF,
  parameter int unsigned OFS_W  = seg_xlate_pkg::SEG_OFS_DEF
) (
  input  logic [BASE_W-1:0] base_i,
  input  logic [OFS_W-1:0]  ofs_i,
  output logic [BASE_W-1:0] sum_o
);
  assign sum_o = base_i + BASE_W'(ofs_i);
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit #(
  parameter int unsigned NUM_SEG = seg_xlate_pkg::SEG_NUM_DEF,
  parameter int unsigned BASE_W  = seg_xlate_pkg::SEG_BASE_DEF,
  parameter int unsigned LIM_W   = seg_xlate_pkg::SEG_LIM_DEF,
  parameter int unsigned OFS_W   = seg_xlate_pkg::SEG_OFS_DEF,
  localparam int unsigned SEL_W  = $clog2(NUM_SEG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prot_mode_i,
  input  logic              cfg_we_i,
  input  logic [SEL_W-1:0]  cfg_idx_i,
  input  logic [BASE_W-1:0] cfg_base_i,
  input  logic [LIM_W-1:0]  cfg_limit_i,
  input  logic              cfg_valid_i,
  input  logic              req_valid_i,
  input  logic [SEL_W-1:0]  req_sel_i,
  input  logic [OFS_W-1:0]  req_ofs_i,
  output logic              rsp_valid_o,
  output logic              rsp_ok_o,
  output logic              rsp_fault_o,
  output logic [BASE_W-1:0] rsp_paddr_o
);
  import seg_xlate_pkg::*;

  logic [BASE_W-1:0] d_base, sum;
  logic [LIM_W-1:0]  d_limit;
  logic              d_valid, fault;
  rsp_kind_e         kind_d, kind_q;
  logic [BASE_W-1:0] paddr_q;

  seg_desc_table #(.NUM_SEG(NUM_SEG), .BASE_W(BASE_W), .LIM_W(LIM_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .prot_i     (prot_mode_i),
    .wr_en_i    (cfg_we_i),
    .wr_idx_i   (cfg_idx_i),
    .wr_base_i  (cfg_base_i),
    .wr_limit_i (cfg_limit_i),
    .wr_valid_i (cfg_valid_i),
    .rd_sel_i   (req_sel_i),
    .rd_base_o  (d_base),
    .rd_limit_o (d_limit),
    .rd_valid_o (d_valid)
  );

  seg_bound_check #(.LIM_W(LIM_W), .OFS_W(OFS_W)) u_bound (
    .ofs_i        (req_ofs_i),
    .limit_i      (d_limit),
    .desc_valid_i (d_valid),
    .fault_o      (fault)
  );

  seg_reloc_add #(.BASE_W(BASE_W), .OFS_W(OFS_W)) u_add (
    .base_i (d_base),
    .ofs_i  (req_ofs_i),
    .sum_o  (sum)
  );

  always_comb begin
    if (!req_valid_i) kind_d = RSP_IDLE;
    else if (fault)   kind_d = RSP_FAULT;
    else              kind_d = RSP_GRANT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q  <= RSP_IDLE;
      paddr_q <= '0;
    end else begin
      kind_q  <= kind_d;
      // suppressed access drives no address
      paddr_q <= (kind_d == RSP_GRANT) ? sum : '0;
    end
  end

  assign rsp_valid_o = (kind_q != RSP_IDLE);
  assign rsp_ok_o    = (kind_q == RSP_GRANT);
  assign rsp_fault_o = (kind_q == RSP_FAULT);
  assign rsp_paddr_o = paddr_q;
endmodule

// File: rtl/seg_xlate_checker.sv
module seg_xlate_checker #(
  parameter int unsigned BASE_W = seg_xlate_pkg::SEG_BASE_DEF,
  parameter int unsigned LIM_W  = seg_xlate_pkg::SEG_LIM_DEF,
  parameter int unsigned OFS_W  = seg_xlate_pkg::SEG_OFS_DEF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [OFS_W-1:0]  req_ofs_i,
  input logic              rsp_valid_o,
  input logic              rsp_ok_o,
  input logic              rsp_fault_o,
  input logic [BASE_W-1:0] rsp_paddr_o
);
  logic ofs_high;
  assign ofs_high = |(req_ofs_i >> LIM_W);

  a_r2_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  a_r3_high_ofs_faults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ofs_high) |=> rsp_fault_o);

  a_r5_fault_suppress: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> (!rsp_ok_o && rsp_paddr_o == '0));

  a_r5_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $onehot({rsp_ok_o, rsp_fault_o}));

  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && !rsp_ok_o && !rsp_fault_o && rsp_paddr_o == '0));
endmodule

bind seg_xlate_unit seg_xlate_checker #(.BASE_W(BASE_W), .LIM_W(LIM_W), .OFS_W(OFS_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ofs_i   (req_ofs_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_ok_o    (rsp_ok_o),
  .rsp_fault_o (rsp_fault_o),
  .rsp_paddr_o (rsp_paddr_o)
);

// File: tb/seg_xlate_unit_tb.sv
`timescale 1ns/1ps
module seg_xlate_unit_tb_top;
  localparam int NS = 8;
  localparam int LW = 20;
  localparam int OW = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prot = 1'b0, we = 1'b0, cvalid = 1'b0, rvalid = 1'b0;
  logic [2:0]  cidx = '0, rsel = '0;
  logic [31:0] cbase = '0;
  logic [19:0] clim = '0;
  logic [23:0] rofs = '0;
  logic        o_valid, o_ok, o_fault;
  logic [31:0] o_paddr;

  logic [31:0] m_base [NS];
  logic [19:0] m_lim  [NS];
  logic        m_val  [NS];

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  seg_xlate_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .prot_mode_i(prot),
    .cfg_we_i(we), .cfg_idx_i(cidx), .cfg_base_i(cbase), .cfg_limit_i(clim), .cfg_valid_i(cvalid),
    .req_valid_i(rvalid), .req_sel_i(rsel), .req_ofs_i(rofs),
    .rsp_valid_o(o_valid), .rsp_ok_o(o_ok), .rsp_fault_o(o_fault), .rsp_paddr_o(o_paddr)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic wr(input int idx, input logic [31:0] b, input logic [19:0] l, input logic v, input logic p);
    @(negedge clk);
    we = 1'b1; prot = p; cidx = 3'(idx); cbase = b; clim = l; cvalid = v;
    @(negedge clk);
    we = 1'b0; prot = 1'b0;
    if (p) begin m_base[idx] = b; m_lim[idx] = l; m_val[idx] = v; end
  endtask

  // expected response from the model for selector s and offset o
  task automatic xlate(input string tag, input int s, input logic [23:0] o);
    logic ok;
    @(negedge clk);
    rvalid = 1'b1; rsel = 3'(s); rofs = o;
    @(posedge clk); #1;
    ok = m_val[s] && ({8'h0, o} <= {12'h0, m_lim[s]});
    chk({tag, " valid"}, {31'h0, o_valid}, 32'h1);
    chk({tag, " ok"},    {31'h0, o_ok},    {31'h0, ok});
    chk({tag, " fault"}, {31'h0, o_fault}, {31'h0, !ok});
    chk({tag, " paddr"}, o_paddr, ok ? (m_base[s] + {8'h0, o}) : 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) begin m_base[i] = '0; m_lim[i] = '0; m_val[i] = 1'b0; end
    #12; rst_n = 1'b1;
    // R1: reset state
    @(negedge clk);
    chk("R1 valid", {31'h0, o_valid}, 32'h0);
    chk("R1 ok",    {31'h0, o_ok},    32'h0);
    chk("R1 fault", {31'h0, o_fault}, 32'h0);
    chk("R1 paddr", o_paddr, 32'h0);
    for (int s = 0; s < NS; s++) xlate("R1 R4 unprogrammed", s, 24'h0);

    // R7 program table; entry 7 stays invalid, 6 wraps, 5 zero limit, 4 full limit
    wr(0, 32'h1000_0000, 20'h00FFF, 1'b1, 1'b1);
    wr(1, 32'h2000_0400, 20'h00010, 1'b1, 1'b1);
    wr(2, 32'h0000_0000, 20'h12345, 1'b1, 1'b1);
    wr(3, 32'h8000_0000, 20'h00001, 1'b1, 1'b1);
    wr(4, 32'h4000_0000, 20'hFFFFF, 1'b1, 1'b1);
    wr(5, 32'h0ABC_DEF0, 20'h00000, 1'b1, 1'b1);
    wr(6, 32'hFFFF_FFF0, 20'h00100, 1'b1, 1'b1);
    wr(7, 32'h5555_0000, 20'h00FFF, 1'b0, 1'b1);

    // R2 R3 R4 R9 sweep around each limit
    for (int s = 0; s < NS; s++) begin
      logic [23:0] l = {4'h0, m_lim[s]};
      xlate("R2 zero", s, 24'h0);
      if (l != 0) xlate("R3 below", s, l - 24'h1);
      xlate("R3 at", s, l);
      xlate("R3 above", s, l + 24'h1);
      xlate("R3 maxlim", s, 24'h0F_FFFF);
      xlate("R3 high", s, 24'h10_0000 | 24'(s * 37));
      for (int k = 0; k < 6; k++) xlate("R2 spread", s, 24'((k * 7919 + s * 1111) % (int'(l) + 2)));
    end
    xlate("R2 wrap", 6, 24'h20);

    // R6 writes outside protected mode leave the table alone
    wr(0, 32'hDEAD_0000, 20'h00002, 1'b0, 1'b0);
    wr(7, 32'h0000_1000, 20'hFFFFF, 1'b1, 1'b0);
    xlate("R6 entry0 kept", 0, 24'h800);
    xlate("R6 entry0 limit kept", 0, 24'h3);
    xlate("R6 entry7 invalid", 7, 24'h10);

    // R7 same-cycle write and request sees old value, next cycle sees new
    @(negedge clk);
    we = 1'b1; prot = 1'b1; cidx = 3'd1; cbase = 32'h3000_0000; clim = 20'h00020; cvalid = 1'b1;
    rvalid = 1'b1; rsel = 3'd1; rofs = 24'h18;
    @(posedge clk); #1;
    chk("R7 old fault", {31'h0, o_fault}, 32'h1);
    chk("R7 old paddr", o_paddr, 32'h0);
    m_base[1] = 32'h3000_0000; m_lim[1] = 20'h00020; m_val[1] = 1'b1;
    @(negedge clk); we = 1'b0; prot = 1'b0;
    @(posedge clk); #1;
    chk("R7 new ok",    {31'h0, o_ok}, 32'h1);
    chk("R7 new paddr", o_paddr, 32'h3000_0018);

    // R8 idle after request drops
    @(negedge clk); rvalid = 1'b0;
    @(posedge clk); #1;
    chk("R8 valid", {31'h0, o_valid}, 32'h0);
    chk("R8 ok",    {31'h0, o_ok},    32'h0);
    chk("R8 fault", {31'h0, o_fault}, 32'h0);
    chk("R8 paddr", o_paddr, 32'h0);

    done = 1;
    finish_run();
  end
endmodule